// File: doc/BRIEF.md
# Byte/Word Read-Only Memory Bus Responder

This block answers read cycles on a 16-bit parallel memory bus the way a one-time-programmable memory does. It samples an address, an active-low chip select (`ce_n`), an active-low output enable (`oe_n`), a byte/word mode select, a low-order byte select bit and an identify flag on each rising clock edge. It returns a 16-bit data word, one output enable for each 8-bit lane and a `data_ok` flag. The data comes from an internal array or, in identify mode, from two fixed codes. The identify flag stands in for the raised voltage that a programmer places on an address pin.

Access timing is given in clock cycles. Three saturating counters track how long the address has been steady, how long `ce_n` has been low and how long `oe_n` has been low. Data is presented only when all three counters have reached their limits. Any change to the address or mode restarts the address counter, so stale data is never held past an address change. Deselecting the block or disabling its outputs releases both lanes on the next edge.

By default the array starts in the erased state, all ones. A parameter can instead fill it with a computed test pattern.

Top module: `eprom_responder`

## Requirements
- R1: While the sampled `ce_n` is 1, `lane_oe` is 2'b00, `data_ok` is 0 and `dout` is 0, whatever `oe_n` is. This is also the state right after reset.
- R2: While the sampled `ce_n` is 0 and the sampled `oe_n` is 1, `lane_oe` is 2'b00 and `data_ok` is 0.
- R3: In word mode (`byte_sel`=0) with both enables low, `lane_oe` is 2'b11 and a valid `dout` equals the array word at `addr`. With `INIT_MODE`=1 the word at address a is ((a*16'h9E37) mod 2^16) XOR 16'h5A5A.
- R4: In byte mode (`byte_sel`=1), `lane_oe` bit 1 (upper lane, `dout[15:8]`) is 0 and `dout[15:8]` is 0. `lane_oe` bit 0 (lower lane) follows the selection. A valid `dout[7:0]` carries word bits 15:8 when `lsb_in`=1 and word bits 7:0 when `lsb_in`=0.
- R5: With `id_mode`=1, the word is 16'h00C2 when `addr[0]`=0 and 16'hB851 when `addr[0]`=1, whatever the other address bits are. The byte steering of R4 still applies.
- R6: Both identifier codes have an odd number of ones, with bit 15 acting as the parity bit.
- R7: Inputs are sampled on each rising edge. `data_ok` is 1 after the edge at which all three hold: the address-group input has stayed equal for at least `T_ACC` consecutive samples, `ce_n` has been 0 for at least `T_CE` consecutive samples, and `oe_n` has been 0 for at least `T_OE` consecutive samples. The address group is `addr`, `byte_sel`, `id_mode`, and `lsb_in` when in byte mode. A change in the address group therefore clears `data_ok` at the very next edge.
- R8: With `INIT_MODE`=0 every array word reads as 16'hFFFF.
- R9: `dout` is 16'h0000 whenever `data_ok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| byte_sel | input | 1 | 1 selects byte mode, 0 selects word mode |
| lsb_in | input | 1 | Byte-mode low address bit, selecting the half of the word |
| id_mode | input | 1 | Identify mode, returning the fixed codes |
| dout | output | 16 | Read data, zero when not valid |
| lane_oe | output | 2 | Output enable per lane: bit 0 for dout[7:0], bit 1 for dout[15:8] |
| data_ok | output | 1 | Read data on dout is valid |

## Verification
`lane_oe` changes one edge after the changed inputs are sampled. `dout` and `data_ok` become valid at the edge where the slowest of the three access counters reaches its limit. With the bench timing of 3, 5 and 2 cycles, that is 5 edges after leaving standby, 3 after an address or mode change and 2 after `oe_n` falls. The bench drives inputs on falling edges and advances its own counting model on rising edges. It compares all outputs at every falling edge, so each result is checked in the exact cycle it is due. Directed cases count the falling edges until `data_ok` rises and compare that count with the expected latency.

// File: rtl/eprom_responder.sv
module eprom_responder #(
  parameter int          ADDR_W    = 10,
  parameter int          T_ACC     = 4,
  parameter int          T_CE      = 4,
  parameter int          T_OE      = 2,
  parameter bit          INIT_MODE = 1'b0,
  parameter logic [14:0] MFR_BASE  = 15'h00C2,
  parameter logic [14:0] DEV_BASE  = 15'h3851
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              byte_sel,
  input  logic              lsb_in,
  input  logic              id_mode,
  output logic [15:0]       dout,
  output logic [1:0]        lane_oe,
  output logic              data_ok
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int T_AC2 = (T_ACC > T_CE) ? T_ACC : T_CE;
  localparam int T_MAX = (T_AC2 > T_OE) ? T_AC2 : T_OE;
  localparam int CW    = (T_MAX < 1) ? 1 : $clog2(T_MAX + 1);
  localparam logic [CW-1:0] LIM_ACC = CW'(T_ACC);
  localparam logic [CW-1:0] LIM_CE  = CW'(T_CE);
  localparam logic [CW-1:0] LIM_OE  = CW'(T_OE);
  localparam logic [CW-1:0] LIM_TOP = CW'(T_MAX);
  localparam logic [15:0] MFR_CODE = {~^MFR_BASE, MFR_BASE};
  localparam logic [15:0] DEV_CODE = {~^DEV_BASE, DEV_BASE};

  function automatic logic [15:0] fill_word(input int idx);
    logic [15:0] p;
    p = 16'(idx) * 16'h9E37;
    return INIT_MODE ? (p ^ 16'h5A5A) : 16'hFFFF;
  endfunction

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return (c >= LIM_TOP) ? LIM_TOP : c + 1'b1;
  endfunction

  logic [15:0] mem [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) mem[i] = fill_word(i);

  logic [ADDR_W-1:0] addr_q;
  logic              ce_q, oe_q, byte_q, lsb_q, id_q;
  logic [CW-1:0]     acc_cnt, ce_cnt, oe_cnt;

  wire moved = (addr != addr_q) || (byte_sel != byte_q) || (id_mode != id_q) ||
               (byte_sel && (lsb_in != lsb_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      byte_q  <= 1'b0;
      lsb_q   <= 1'b0;
      id_q    <= 1'b0;
      acc_cnt <= '0;
      ce_cnt  <= '0;
      oe_cnt  <= '0;
    end else begin
      addr_q  <= addr;
      ce_q    <= ce_n;
      oe_q    <= oe_n;
      byte_q  <= byte_sel;
      lsb_q   <= lsb_in;
      id_q    <= id_mode;
      acc_cnt <= moved ? CW'(1) : bump(acc_cnt);
      ce_cnt  <= ce_n ? '0 : bump(ce_cnt);
      oe_cnt  <= oe_n ? '0 : bump(oe_cnt);
    end
  end

  wire        picked = !ce_q && !oe_q;
  wire        ready  = (acc_cnt >= LIM_ACC) && (ce_cnt >= LIM_CE) && (oe_cnt >= LIM_OE);
  wire [15:0] word   = id_q ? (addr_q[0] ? DEV_CODE : MFR_CODE) : mem[addr_q];
  wire [7:0]  half   = lsb_q ? word[15:8] : word[7:0];

  assign data_ok = picked && ready;
  assign lane_oe = {picked && !byte_q, picked};
  assign dout    = !data_ok ? 16'h0000 : (byte_q ? {8'h00, half} : word);

endmodule

// File: rtl/eprom_responder_chk.sv
module eprom_responder_chk #(
  parameter int ADDR_W = 10,
  parameter int T_ACC  = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              byte_sel,
  input logic              id_mode,
  input logic [15:0]       dout,
  input logic [1:0]        lane_oe,
  input logic              data_ok
);

  AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> (lane_oe == 2'b00 && !data_ok)); // R1

  AST_OUTPUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ce_n) && $past(oe_n)) |-> (lane_oe == 2'b00 && !data_ok)); // R2

  AST_WORD_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ce_n) && !$past(oe_n) && !$past(byte_sel)) |-> (lane_oe == 2'b11)); // R3

  AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(byte_sel) |-> (!lane_oe[1] && dout[15:8] == 8'h00)); // R4

  AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ok && $past(id_mode) && !$past(byte_sel)) |-> ($countones(dout) % 2 == 1)); // R6

  AST_VALID_NEEDS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    data_ok |-> lane_oe[0]); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ok |-> (dout == 16'h0000)); // R9

  if (T_ACC > 1) begin : g_hold
    AST_ADDR_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != $past(addr)) |=> !data_ok); // R7
  end

endmodule

bind eprom_responder eprom_responder_chk #(.ADDR_W(ADDR_W), .T_ACC(T_ACC)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
  .byte_sel(byte_sel), .id_mode(id_mode), .dout(dout), .lane_oe(lane_oe),
  .data_ok(data_ok)
);

// File: tb/sim_eprom_responder.sv
`timescale 1ns/1ps
module sim_eprom_responder;
  localparam int AW = 10, TA = 3, TC = 5, TO = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, byte_sel = 1'b0, lsb_in = 1'b0, id_mode = 1'b0;
  logic [15:0] dout, dout1;
  logic [1:0]  lane, lane1;
  logic        ok, ok1;
  int checks = 0, errors = 0;
  bit live = 1'b0, done = 1'b0;

  eprom_responder #(.ADDR_W(AW), .T_ACC(TA), .T_CE(TC), .T_OE(TO), .INIT_MODE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .byte_sel(byte_sel),
    .lsb_in(lsb_in), .id_mode(id_mode), .dout(dout), .lane_oe(lane), .data_ok(ok));

  eprom_responder #(.ADDR_W(AW)) u1 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .byte_sel(byte_sel),
    .lsb_in(lsb_in), .id_mode(id_mode), .dout(dout1), .lane_oe(lane1), .data_ok(ok1));

  always #2 clk = ~clk;

  function automatic logic [15:0] patt(input int a);
    int v;
    v = ((a * 40503) & 65535) ^ 23130;
    return v[15:0];
  endfunction

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  int m_acc, m_cen, m_oen;
  logic [AW-1:0] m_addr;
  logic m_ce_n, m_oe_n, m_byte, m_lsb, m_id;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_cen = 0; m_oen = 0;
      m_addr = '0; m_ce_n = 1; m_oe_n = 1; m_byte = 0; m_lsb = 0; m_id = 0;
    end else begin
      if (addr != m_addr || byte_sel != m_byte || id_mode != m_id ||
          (byte_sel && lsb_in != m_lsb)) m_acc = 1;
      else m_acc++;
      m_cen = ce_n ? 0 : m_cen + 1;
      m_oen = oe_n ? 0 : m_oen + 1;
      m_addr = addr; m_ce_n = ce_n; m_oe_n = oe_n;
      m_byte = byte_sel; m_lsb = lsb_in; m_id = id_mode;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      logic sel, e_ok;
      logic [15:0] w, e_d;
      logic [1:0] e_l;
      string lt, dt;
      sel  = !m_ce_n && !m_oe_n;
      e_ok = sel && m_acc >= TA && m_cen >= TC && m_oen >= TO;
      w    = m_id ? (m_addr[0] ? 16'hB851 : 16'h00C2) : patt(int'(m_addr));
      e_d  = !e_ok ? 16'h0 : (m_byte ? {8'h0, (m_lsb ? w[15:8] : w[7:0])} : w);
      e_l  = {sel && !m_byte, sel};
      lt   = m_ce_n ? "R1" : (m_oe_n ? "R2" : (m_byte ? "R4" : "R3"));
      dt   = !e_ok ? "R9" : (m_id ? "R5" : (m_byte ? "R4" : "R3"));
      chk(lane == e_l, lt, "lane_oe", 32'(lane), 32'(e_l));
      chk(ok == e_ok, "R7", "data_ok", 32'(ok), 32'(e_ok));
      chk(dout == e_d, dt, "dout", 32'(dout), 32'(e_d));
    end
  end

  task automatic lat(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ok && n < 20);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] lf;
    repeat (4) @(negedge clk);
    chk(lane == 2'b00 && !ok && dout == 0, "R1", "reset idle", {lane, ok, dout}, 32'h0);
    rst_n = 1'b1;
    live  = 1'b1;
    @(negedge clk);
    chk(lane == 2'b00 && !ok, "R1", "idle after reset", {lane, ok}, 32'h0);

    addr = 10'd5; ce_n = 0; oe_n = 0;
    lat(n);
    chk(n == 5, "R7", "latency from standby", n, 5);
    chk(dout == patt(5), "R3", "word at 5", dout, patt(5));
    chk(lane == 2'b11, "R3", "both lanes", lane, 2'b11);

    addr = 10'h2A5;
    @(negedge clk);
    chk(!ok && dout == 0, "R7", "zero hold on address change", {ok, dout}, 0);
    n = 1;
    while (!ok && n < 20) begin @(negedge clk); n++; end
    chk(n == 3, "R7", "latency after address change", n, 3);
    chk(dout == patt(10'h2A5), "R3", "word at 2A5", dout, patt(10'h2A5));

    oe_n = 1;
    @(negedge clk);
    chk(lane == 2'b00 && !ok, "R2", "output disabled", {lane, ok}, 0);
    chk(dout == 0, "R9", "dout zero when not valid", dout, 0);
    oe_n = 0;
    lat(n);
    chk(n == 2, "R7", "latency after oe falls", n, 2);

    ce_n = 1;
    @(negedge clk);
    chk(lane == 2'b00 && !ok && dout == 0, "R1", "standby with oe low", {lane, ok, dout}, 0);
    ce_n = 0;
    repeat (6) @(negedge clk);

    byte_sel = 1; lsb_in = 0; addr = 10'h011;
    lat(n);
    chk(n == 3, "R7", "latency after mode change", n, 3);
    chk(lane == 2'b01, "R4", "upper lane off", lane, 2'b01);
    chk(dout == {8'h0, patt(17)} [7:0], "R4", "low half", dout, {8'h0, patt(17)} [7:0]);
    lsb_in = 1;
    lat(n);
    chk(n == 3, "R7", "latency after lsb change", n, 3);
    chk(dout == {8'h0, patt(17) >> 8}, "R4", "high half", dout, {8'h0, patt(17) >> 8});

    byte_sel = 0; id_mode = 1; addr = 10'h000;
    lat(n);
    chk(dout == 16'h00C2, "R5", "maker code", dout, 16'h00C2);
    chk($countones(dout) % 2 == 1, "R6", "maker parity", $countones(dout), 1);
    addr = 10'h001;
    lat(n);
    chk(dout == 16'hB851, "R5", "device code", dout, 16'hB851);
    chk($countones(dout) % 2 == 1, "R6", "device parity", $countones(dout), 1);
    addr = 10'h3F0;
    lat(n);
    chk(dout == 16'h00C2, "R5", "high address bits ignored", dout, 16'h00C2);
    byte_sel = 1; lsb_in = 1; addr = 10'h3F1;
    lat(n);
    chk(dout == 16'h00B8, "R5", "device code upper byte", dout, 16'h00B8);

    byte_sel = 0; id_mode = 0; addr = 10'h123;
    repeat (8) @(negedge clk);
    chk(ok1 && dout1 == 16'hFFFF, "R8", "erased word", {ok1, dout1}, {1'b1, 16'hFFFF});
    addr = 10'h3FF;
    repeat (8) @(negedge clk);
    chk(ok1 && dout1 == 16'hFFFF, "R8", "erased last word", {ok1, dout1}, {1'b1, 16'hFFFF});

    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2:0] == 3'd0) addr = lf[12:3];
      ce_n     = (lf[7:4] == 4'd0);
      oe_n     = (lf[11:8] == 4'd1);
      if (lf[15:12] == 4'd3) byte_sel = ~byte_sel;
      if (lf[15:13] == 3'd6) lsb_in = ~lsb_in;
      if (lf[15:11] == 5'd5) id_mode = ~id_mode;
    end
    @(negedge clk);
    live = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule